// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory address of a load or store from the operands the instruction selects. A 3-bit mode code picks which parts are added: a displacement, a base register value, an index register value (optionally scaled), or the instruction pointer. In the two real-mode sizes the block picks a segment, either by default from the base register or from an explicit override, and relocates the offset by that segment value. In flat mode the sum is the linear address and no segment takes part.

Each accepted request yields one result a clock later. That result holds the address of the low byte, the address of the byte above it (so a word access can reach both bytes), the segment that was used and an error flag. Register-file reads, decode, the memory access, protection and paging are handled elsewhere.

Top module: `seg_agu`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. A synchronous `rst` clears it.
- R2: The mode code `addr_mode` selects the sum. 0 is disp. 1 is base. 2 is base+index. 3 is base+disp. 4 is base+index+disp. 5 is the scaled mode. 6 is ip+disp. `disp` is always sign-extended from 32 bits, and the scale is not applied in modes 2 and 4.
- R3: In mode 5 the sum is (base_en ? base : 0) + (index << scale), where scale 0,1,2,3 means ×1,×2,×4,×8. Mode 5 adds no displacement.
- R4: The default segment is SS (`out_seg`=01) when a base is in use and `base_sel` is 4 (stack pointer) or 5 (frame pointer). It is DS (00) for any other base, in mode 0, and in mode 5 with `base_en` low.
- R5: In real mode, `seg_ovr` 00, 01 or 10 selects DS, SS or ES in place of the default segment. 11 keeps the default.
- R6: Real mode uses `size_mode` 00 or 01. The offset is the sum modulo 2^16 (00) or modulo 2^32 (01). The address is segment×16 + offset.
- R7: With `size_mode` 10, the address is the sum modulo 2^64. `out_seg` is 11, and `seg_ovr` and the segment values have no effect.
- R8: Mode 6 gives ip + sign-extended disp modulo 2^64, with `out_seg` 11, whatever `size_mode` is (except the reserved 11).
- R9: Mode 7, `size_mode` 11, or mode 3 with `base_sel` 4 raises `out_err`. In that case `out_addr`, `out_addr_hi` and `out_seg` are all zero.
- R10: `out_addr_hi` is the address of the high byte of a little-endian word. It is computed as (sum+1), wrapped in the offset width and relocated by the same segment. In flat mode it is `out_addr`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| in_valid | input | 1 | request present this cycle |
| addr_mode | input | 3 | address mode code |
| size_mode | input | 2 | 00 real 16-bit offset, 01 real 32-bit offset, 10 flat, 11 reserved |
| base_sel | input | 4 | number of the base register (4 stack pointer, 5 frame pointer) |
| base_en | input | 1 | base present in the scaled mode |
| base_val | input | 64 | base register value |
| index_val | input | 64 | index register value |
| scale | input | 2 | index shift in the scaled mode |
| disp | input | 32 | signed displacement |
| seg_ovr | input | 2 | segment override (00 DS, 01 SS, 10 ES, 11 none) |
| seg_ds | input | 16 | data segment value |
| seg_ss | input | 16 | stack segment value |
| seg_es | input | 16 | extra segment value |
| ip | input | 64 | instruction pointer |
| out_valid | output | 1 | result valid |
| out_err | output | 1 | illegal request |
| out_seg | output | 2 | segment used (00 DS, 01 SS, 10 ES, 11 none) |
| out_addr | output | 64 | address of the low byte |
| out_addr_hi | output | 64 | address of the high byte |

## Verification
Every result is due exactly one rising edge after its request. The bench drives a request on a falling edge. On the next falling edge it compares all five outputs with the value its reference model computed from that request, before it drives the following request. Idle cycles are compared in the same way, so a valid pulse that is late, early or stretched shows as a mismatch in the cycle where it appears.

// File: rtl/seg_agu.sv
module seg_agu #(
  parameter int AW     = 64,
  parameter int DW     = 32,
  parameter int SW     = 16,
  parameter int RSEL_W = 4,
  parameter int SP_ID  = 4,
  parameter int BP_ID  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        addr_mode,
  input  logic [1:0]        size_mode,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic              base_en,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [1:0]        scale,
  input  logic [DW-1:0]     disp,
  input  logic [1:0]        seg_ovr,
  input  logic [SW-1:0]     seg_ds,
  input  logic [SW-1:0]     seg_ss,
  input  logic [SW-1:0]     seg_es,
  input  logic [AW-1:0]     ip,
  output logic              out_valid,
  output logic              out_err,
  output logic [1:0]        out_seg,
  output logic [AW-1:0]     out_addr,
  output logic [AW-1:0]     out_addr_hi
);
  localparam int SEG_SH = 4;
  localparam int OFF16  = 16;
  localparam int OFF32  = 32;
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_BI  = 3'd2, M_REL = 3'd3,
                         M_BID = 3'd4, M_SCL = 3'd5, M_IPR = 3'd6;
  localparam logic [1:0] S_DS = 2'd0, S_SS = 2'd1, S_ES = 2'd2, S_NONE = 2'd3;

  logic [AW-1:0] disp_x, idx_s, sum, sum1, off, off1, seg_base, addr_n, addr_hi_n;
  logic          has_base, flat, err, stack_base;
  logic [1:0]    seg_dflt, seg_sel, seg_n;
  logic [SW-1:0] seg_val;

  assign disp_x = {{(AW-DW){disp[DW-1]}}, disp};
  assign idx_s  = index_val << scale;

  always_comb begin
    has_base = 1'b1;
    sum      = '0;
    case (addr_mode)
      M_DIR: begin sum = disp_x; has_base = 1'b0; end
      M_IND: sum = base_val;
      M_BI:  sum = base_val + index_val;
      M_REL: sum = base_val + disp_x;
      M_BID: sum = base_val + index_val + disp_x;
      M_SCL: begin
        sum      = (base_en ? base_val : '0) + idx_s;
        has_base = base_en;
      end
      M_IPR: begin sum = ip + disp_x; has_base = 1'b0; end
      default: has_base = 1'b0;
    endcase
  end

  assign sum1 = sum + AW'(1);

  assign err = (addr_mode == 3'd7) || (size_mode == 2'b11) ||
               (addr_mode == M_REL && base_sel == RSEL_W'(SP_ID));

  assign flat = (size_mode == 2'b10) || (addr_mode == M_IPR);

  always_comb begin
    case (size_mode)
      2'b00:   begin off = AW'(sum[OFF16-1:0]); off1 = AW'(sum1[OFF16-1:0]); end
      2'b01:   begin off = AW'(sum[OFF32-1:0]); off1 = AW'(sum1[OFF32-1:0]); end
      default: begin off = sum;                 off1 = sum1;                 end
    endcase
  end

  assign stack_base = has_base &&
                      (base_sel == RSEL_W'(SP_ID) || base_sel == RSEL_W'(BP_ID));
  assign seg_dflt   = stack_base ? S_SS : S_DS;
  assign seg_sel    = (seg_ovr == S_NONE) ? seg_dflt : seg_ovr;

  always_comb begin
    case (seg_sel)
      S_SS:    seg_val = seg_ss;
      S_ES:    seg_val = seg_es;
      default: seg_val = seg_ds;
    endcase
  end

  assign seg_base = AW'(seg_val) << SEG_SH;

  always_comb begin
    if (err) begin
      addr_n    = '0;
      addr_hi_n = '0;
      seg_n     = S_DS;
    end else if (flat) begin
      addr_n    = sum;
      addr_hi_n = sum1;
      seg_n     = S_NONE;
    end else begin
      addr_n    = seg_base + off;
      addr_hi_n = seg_base + off1;
      seg_n     = seg_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_err     <= err;
      out_seg     <= seg_n;
      out_addr    <= addr_n;
      out_addr_hi <= addr_hi_n;
    end
  end
endmodule

module seg_agu_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    size_mode,
  input logic          out_valid,
  input logic          out_err,
  input logic [1:0]    out_seg,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_addr_hi
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> !out_valid);
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_addr == '0 && out_addr_hi == '0 && out_seg == 2'b00));
  p_real_range_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && out_seg != 2'b11) |-> (out_addr >> 33) == '0);
  p_flat_hi_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && out_seg == 2'b11) |-> out_addr_hi == out_addr + AW'(1));
  p_reserved_size_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_mode == 2'b11) |=> out_err);
endmodule

bind seg_agu seg_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .size_mode(size_mode),
  .out_valid(out_valid), .out_err(out_err), .out_seg(out_seg),
  .out_addr(out_addr), .out_addr_hi(out_addr_hi)
);

// File: tb/seg_agu_tb.sv
`timescale 1ns/1ps
module seg_agu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  addr_mode = '0;
  logic [1:0]  size_mode = '0;
  logic [3:0]  base_sel = '0;
  logic        base_en = 1'b0;
  logic [63:0] base_val = '0, index_val = '0, ip = '0;
  logic [1:0]  scale = '0;
  logic [31:0] disp = '0;
  logic [1:0]  seg_ovr = 2'b11;
  logic [15:0] seg_ds = '0, seg_ss = '0, seg_es = '0;
  logic        out_valid, out_err;
  logic [1:0]  out_seg;
  logic [63:0] out_addr, out_addr_hi;

  int n_cmp = 0, n_bad = 0;
  bit e_v = 0, e_err = 0;
  bit [1:0] e_seg = 0;
  bit [63:0] e_a = 0, e_h = 0;
  string e_tag = "R1";

  always #2.5 clk = ~clk;

  seg_agu u_dut (.*);

  task automatic model(input string tag);
    bit [63:0] d, s, msk, sv;
    bit [1:0] dseg, sel;
    bit hb;
    d  = {{32{disp[31]}}, disp};
    hb = 1;
    s  = 0;
    case (addr_mode)
      3'd0: begin s = d; hb = 0; end
      3'd1: s = base_val;
      3'd2: s = base_val + index_val;
      3'd3: s = base_val + d;
      3'd4: s = base_val + index_val + d;
      3'd5: begin s = (base_en ? base_val : 64'd0) + index_val * (64'd1 << scale); hb = base_en; end
      3'd6: begin s = ip + d; hb = 0; end
      default: hb = 0;
    endcase
    e_v = in_valid;
    e_tag = tag;
    if (!in_valid) return;
    e_err = (addr_mode == 7) || (size_mode == 3) || (addr_mode == 3 && base_sel == 4);
    if (e_err) begin
      e_a = 0; e_h = 0; e_seg = 0;
    end else if (size_mode == 2 || addr_mode == 6) begin
      e_a = s; e_h = s + 1; e_seg = 3;
    end else begin
      msk  = (size_mode == 0) ? 64'hFFFF : 64'hFFFF_FFFF;
      dseg = (hb && (base_sel == 4 || base_sel == 5)) ? 2'd1 : 2'd0;
      sel  = (seg_ovr == 3) ? dseg : seg_ovr;
      sv   = (sel == 1) ? seg_ss : (sel == 2) ? seg_es : seg_ds;
      e_a  = sv * 16 + (s & msk);
      e_h  = sv * 16 + ((s + 1) & msk);
      e_seg = sel;
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (out_valid !== e_v) begin
      n_bad++;
      $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, e_v);
    end else if (e_v) begin
      if (out_err !== e_err) begin
        n_bad++; $display("FAIL R9 (%s) out_err act=%0b exp=%0b", e_tag, out_err, e_err);
      end
      if (out_addr !== e_a) begin
        n_bad++; $display("FAIL %s out_addr act=%h exp=%h", e_tag, out_addr, e_a);
      end
      if (out_addr_hi !== e_h) begin
        n_bad++; $display("FAIL R10 (%s) out_addr_hi act=%h exp=%h", e_tag, out_addr_hi, e_h);
      end
      if (out_seg !== e_seg) begin
        n_bad++; $display("FAIL %s out_seg act=%0d exp=%0d", e_tag, out_seg, e_seg);
      end
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    compare();
    model(tag);
  endtask

  task automatic req(input string tag, input bit [2:0] m, input bit [1:0] sz,
                     input bit [3:0] bs, input bit [63:0] b, input bit [63:0] x,
                     input bit [1:0] sc, input bit be, input bit [31:0] dp,
                     input bit [1:0] ov);
    @(negedge clk);
    compare();
    in_valid = 1; addr_mode = m; size_mode = sz; base_sel = bs; base_val = b;
    index_val = x; scale = sc; base_en = be; disp = dp; seg_ovr = ov;
    model(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    seg_ds = 16'h1000; seg_ss = 16'h2000; seg_es = 16'h3000;
    repeat (3) @(negedge clk);
    rst = 0;
    model("R1");
    step("R1");
    // R6 direct: DS 1000H + 1234H -> 11234H
    req("R6", 0, 0, 0, 0, 0, 0, 0, 32'h1234, 3);
    // R4 frame-pointer base -> SS; other base -> DS
    req("R4", 1, 0, 5, 64'h0100, 0, 0, 0, 0, 3);
    req("R4", 1, 0, 3, 64'h0100, 0, 0, 0, 0, 3);
    req("R4", 4, 0, 4, 64'h10, 64'h20, 0, 0, 32'h4, 3);
    // R5 overrides
    req("R5", 1, 0, 5, 64'h0100, 0, 0, 0, 0, 2);
    req("R5", 2, 1, 3, 64'h10, 64'h20, 3, 0, 0, 0);
    // R6 wrap at 2^16 and 2^32; R10 high byte wrap
    req("R6", 3, 0, 3, 64'hFFFF, 0, 0, 0, 32'h2, 3);
    req("R10", 1, 0, 6, 64'hFFFF, 0, 0, 0, 0, 3);
    req("R6", 3, 1, 7, 64'hFFFF_FFFF, 0, 0, 0, 32'h5, 3);
    req("R6", 3, 0, 3, 64'h10, 0, 0, 0, 32'hFFFF_FFFE, 3);
    // R3 scaled index, with and without base
    req("R3", 5, 1, 0, 64'h100, 64'h3, 3, 1, 0, 3);
    req("R3", 5, 1, 5, 64'h100, 64'h3, 1, 0, 32'h77, 3);
    req("R3", 5, 1, 5, 64'h100, 64'h3, 2, 1, 0, 3);
    // R7 flat mode ignores override
    req("R7", 4, 2, 5, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 2, 0, 32'h10, 2);
    // R8 instruction-pointer relative
    ip = 64'h10_0000_0000;
    req("R8", 6, 0, 0, 0, 0, 0, 0, 32'h300, 1);
    req("R8", 6, 1, 0, 0, 0, 0, 0, 32'hFFFF_FF00, 3);
    // R9 illegal cases
    req("R9", 3, 0, 4, 64'h55, 0, 0, 0, 32'h1, 3);
    req("R9", 7, 0, 1, 64'h55, 0, 0, 0, 32'h1, 3);
    req("R9", 1, 3, 1, 64'h55, 0, 0, 0, 32'h1, 3);
    req("R9", 4, 2, 4, 64'h55, 64'h1, 0, 0, 32'h1, 3);
    // R1 idle gap
    @(negedge clk); compare(); in_valid = 0; model("R1");
    step("R1");
    // R2 mixed stimulus
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      compare();
      in_valid  = ($urandom % 4) != 0;
      addr_mode = 3'($urandom);
      size_mode = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      base_sel  = 4'($urandom);
      base_en   = 1'($urandom);
      base_val  = {$urandom, $urandom};
      index_val = ($urandom % 2) ? {$urandom, $urandom} : 64'($urandom % 256);
      scale     = 2'($urandom);
      disp      = $urandom;
      seg_ovr   = 2'($urandom);
      seg_ds    = 16'($urandom); seg_ss = 16'($urandom); seg_es = 16'($urandom);
      ip        = {$urandom, $urandom};
      model("R2");
    end
    // R1 reset clears valid
    @(negedge clk); compare(); in_valid = 1; rst = 1; e_v = 0; e_tag = "R1";
    @(negedge clk); compare(); in_valid = 0; rst = 0; model("R1");
    step("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule